// File: doc/BRIEF.md
# Paced Sample Record and Playback Engine

This block moves 8-bit audio samples between a converter and a memory region without processor attention. In record mode it drives the conversion-start strobe of an external successive-approximation ADC, waits for the converter's busy flag to fall, and writes each converted byte to consecutive RAM addresses. In playback mode it reads consecutive bytes from the same kind of region and loads each into a held DAC output register, marked by a one-cycle strobe.

A pass is launched by a one-cycle `go` pulse that carries a base address, a sample count and a pace value. The pace sets how many idle cycles follow every sample, so one value controls the sample rate of both directions. Each pass walks its region once, raises `done` for one cycle and returns to idle. Software polls `active` or waits for `done`; control pins are plain levels and pulses. The RAM port has no back-pressure: the RAM is expected to take a request in every cycle that `mem_en` is high, and read data is returned in the next cycle. The converter likewise has no ready signal beyond its busy flag.

Top module: `smp_engine`

## Requirements
- R1: During and straight after reset, `active`, `done`, `adc_start`, `mem_en`, `mem_we` and `dac_stb` are low and `dac_out` is zero.
- R2: A record pass of non-zero length opens, in the cycle after `go`, with one `adc_start` pulse that touches no memory, to prime the converter.
- R3: With `fast_mode` low, a sample is written only after the engine has seen `adc_busy` low; the first capture of a pass lands 12 cycles after the `go` cycle.
- R4: Record sample i is written with `mem_we` high to address base+i (modulo the address width) with the data present on `adc_data`, and the same cycle fires `adc_start` for the next conversion.
- R5: The sample period is pace+2 cycles, where a pace of zero acts as one; with the busy check enabled, a record period is never shorter than 11 cycles.
- R6: Playback reads address base+i (a cycle with `mem_en` high and `mem_we` low) and two cycles later `dac_out` shows that byte while `dac_stb` is high for exactly one cycle; `dac_out` holds between strobes. The first read is in the cycle after `go`.
- R7: After the last sample and its pace countdown `done` is high for one cycle; `active` is high from the cycle after `go` up to and including the `done` cycle, and low afterwards.
- R8: A length of zero raises `done` in the cycle after `go` with no memory access and no `adc_start`.
- R9: A `go` pulse while `active` is high is ignored, including the base address and length present with it.
- R10: With `fast_mode` high the busy flag is not consulted: the first capture lands 3 cycles after `go` and each later one pace+2 cycles after the previous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | One-cycle pass launch |
| rec_mode | input | 1 | 1 = record pass, 0 = playback pass |
| fast_mode | input | 1 | 1 = skip the busy check while recording |
| base_addr | input | AW (8) | First address of the region |
| length | input | LW (16) | Number of samples in the pass |
| pace | input | PW (8) | Idle cycles after each sample (0 treated as 1) |
| adc_busy | input | 1 | Converter busy flag |
| adc_data | input | DW (8) | Converter result |
| adc_start | output | 1 | Conversion-start strobe |
| mem_rdata | input | DW (8) | RAM read data, one cycle after the read |
| mem_en | output | 1 | RAM request |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW (8) | RAM address |
| mem_wdata | output | DW (8) | RAM write data |
| dac_out | output | DW (8) | Held DAC output register |
| dac_stb | output | 1 | One-cycle pulse when `dac_out` changes |
| active | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The bench predicts, for every clock, which of the RAM, strobe, done and active pins should be high, so a design that samples while the converter is still busy, miscounts the pace countdown or treats a pace of zero as 256 shows up as a capture or strobe in the wrong cycle. It targets a fast-mode pass whose first capture precedes the end of the priming conversion, a region that wraps past the top address, zero-length passes of both kinds, and a second `go` with a different base and length during a pass; a design that honoured that late `go` would jump addresses or end early. Captured bytes are compared with a numbered sequence from the converter model, so a missed prime or a dropped strobe shifts every value by one.

// File: rtl/smp_pkg.sv
package smp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIME,
    ST_WAIT,
    ST_CAPT,
    ST_RD,
    ST_OUT,
    ST_PACE,
    ST_DONE
  } smp_state_t;
endpackage

// File: rtl/smp_pacer.sv
module smp_pacer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] pace,
  output logic          last
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (pace == '0) ? ONE : pace;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign last = (cnt_q == ONE);

  assert_pace_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q != '0));
endmodule

// File: rtl/smp_walker.sv
module smp_walker #(
  parameter int AW = 8,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] count,
  output logic [AW-1:0] addr,
  output logic          empty
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (load) begin
      addr_q <= base;
      left_q <= count;
    end else if (step) begin
      addr_q <= addr_q + AW'(1);
      left_q <= left_q - LW'(1);
    end
  end

  assign addr  = addr_q;
  assign empty = (left_q == '0);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (left_q != '0));
endmodule

// File: rtl/smp_ctrl.sv
module smp_ctrl
  import smp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic rec,
  input  logic fast,
  input  logic len_zero,
  input  logic adc_busy,
  input  logic pace_last,
  input  logic empty,
  output logic walk_load,
  output logic walk_step,
  output logic pace_load,
  output logic dac_load,
  output logic adc_start,
  output logic mem_en,
  output logic mem_we,
  output logic active,
  output logic done
);
  smp_state_t state_q, state_d;
  logic rec_q, fast_q;
  logic accept;

  assign accept = (state_q == ST_IDLE) && go;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (go) state_d = len_zero ? ST_DONE : (rec ? ST_PRIME : ST_RD);
      ST_PRIME: state_d = ST_WAIT;
      ST_WAIT:  if (fast_q || !adc_busy) state_d = ST_CAPT;
      ST_CAPT:  state_d = ST_PACE;
      ST_RD:    state_d = ST_OUT;
      ST_OUT:   state_d = ST_PACE;
      ST_PACE:  if (pace_last) state_d = empty ? ST_DONE : (rec_q ? ST_WAIT : ST_RD);
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rec_q   <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        rec_q  <= rec;
        fast_q <= fast;
      end
    end
  end

  assign walk_load = accept;
  assign walk_step = (state_q == ST_CAPT) || (state_q == ST_OUT);
  assign pace_load = walk_step;
  assign dac_load  = (state_q == ST_OUT);
  assign adc_start = (state_q == ST_PRIME) || (state_q == ST_CAPT);
  assign mem_en    = (state_q == ST_CAPT) || (state_q == ST_RD);
  assign mem_we    = (state_q == ST_CAPT);
  assign active    = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);

  assert_prime_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rec && !len_zero) |=> (adc_start && !mem_en));

  assert_capture_after_idle_adc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !fast_q) |-> $past(!adc_busy));

  assert_active_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> active);

  assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && len_zero) |=> (done && !mem_en && !adc_start));

  assert_go_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && go && !done) |=> (active && $stable(rec_q) && $stable(fast_q)));
endmodule

// File: rtl/smp_engine.sv
module smp_engine #(
  parameter int AW = 8,
  parameter int LW = 16,
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          rec_mode,
  input  logic          fast_mode,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] length,
  input  logic [PW-1:0] pace,
  input  logic          adc_busy,
  input  logic [DW-1:0] adc_data,
  output logic          adc_start,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] dac_out,
  output logic          dac_stb,
  output logic          active,
  output logic          done
);
  logic walk_load, walk_step, pace_load, dac_load;
  logic pace_last, empty;
  logic [DW-1:0] dac_q;
  logic          stb_q;

  smp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .rec       (rec_mode),
    .fast      (fast_mode),
    .len_zero  (length == '0),
    .adc_busy  (adc_busy),
    .pace_last (pace_last),
    .empty     (empty),
    .walk_load (walk_load),
    .walk_step (walk_step),
    .pace_load (pace_load),
    .dac_load  (dac_load),
    .adc_start (adc_start),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .active    (active),
    .done      (done)
  );

  smp_walker #(.AW(AW), .LW(LW)) u_walker (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (walk_load),
    .step  (walk_step),
    .base  (base_addr),
    .count (length),
    .addr  (mem_addr),
    .empty (empty)
  );

  smp_pacer #(.PW(PW)) u_pacer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (pace_load),
    .pace  (pace),
    .last  (pace_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= dac_load;
      if (dac_load) dac_q <= mem_rdata;
    end
  end

  assign dac_out   = dac_q;
  assign dac_stb   = stb_q;
  assign mem_wdata = adc_data;

  assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_stb |=> !dac_stb);

  assert_dac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_stb |-> $stable(dac_out));

  assert_stb_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_stb |-> $past(mem_en && !mem_we, 2));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !active));

  assert_write_strobes_adc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> adc_busy);
endmodule

// File: tb/smp_engine_tb_top.sv
module smp_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic        rec_mode = 1'b0;
  logic        fast_mode = 1'b0;
  logic [7:0]  base_addr = '0;
  logic [15:0] length = '0;
  logic [7:0]  pace = '0;
  logic        adc_busy;
  logic [7:0]  adc_data;
  logic        adc_start;
  logic [7:0]  mem_rdata;
  logic        mem_en, mem_we;
  logic [7:0]  mem_addr, mem_wdata;
  logic [7:0]  dac_out;
  logic        dac_stb, active, done;

  int total = 0;
  int bad = 0;
  int conv_n = 0;
  int conv_cnt = 0;
  logic [7:0] conv_pend;
  logic [7:0] ram [256];
  logic [7:0] exp_dac = '0;

  always #5 clk = ~clk;

  smp_engine dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .rec_mode(rec_mode), .fast_mode(fast_mode),
    .base_addr(base_addr), .length(length), .pace(pace),
    .adc_busy(adc_busy), .adc_data(adc_data), .adc_start(adc_start),
    .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .dac_out(dac_out), .dac_stb(dac_stb), .active(active), .done(done)
  );

  function automatic logic [7:0] cval(int n);
    int v;
    v = n * 53 + 17;
    return v[7:0];
  endfunction

  // converter model: busy for 9 cycles after each start, result on fall
  always @(posedge clk) begin
    if (!rst_n) begin
      adc_busy <= 1'b0;
      adc_data <= 8'h00;
      conv_cnt <= 0;
    end else if (adc_start) begin
      adc_busy  <= 1'b1;
      conv_cnt  <= 9;
      conv_pend <= cval(conv_n);
      conv_n    <= conv_n + 1;
    end else if (conv_cnt > 1) begin
      conv_cnt <= conv_cnt - 1;
    end else if (conv_cnt == 1) begin
      adc_busy <= 1'b0;
      adc_data <= conv_pend;
      conv_cnt <= 0;
    end
  end

  // synchronous single-port RAM model
  always @(posedge clk) begin
    if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_pass(input bit rec, input bit fst, input logic [7:0] b,
                          input int n, input logic [7:0] p, input int glitch);
    int ev[$];
    int pp, c, done_c, n0, idx;
    bit e_mem, e_we, e_start, e_stb;
    pp = (p == 0) ? 1 : int'(p);
    n0 = conv_n;
    if (n == 0) begin
      done_c = 1;
    end else begin
      c = rec ? (fst ? 3 : 12) : 2;
      for (int i = 0; i < n; i++) begin
        ev.push_back(c);
        if (rec && !fst) c += (pp + 2 > 11) ? pp + 2 : 11;
        else c += pp + 2;
      end
      done_c = ev[n-1] + pp + 1;
    end
    @(negedge clk);
    rec_mode = rec; fast_mode = fst; base_addr = b; length = 16'(n); pace = p; go = 1'b1;
    for (int k = 1; k <= done_c + 1; k++) begin
      @(negedge clk);
      go = 1'b0;
      if (k == glitch) begin
        go = 1'b1; base_addr = 8'd200; length = 16'd1;
      end
      e_mem = 0; e_we = 0; e_start = 0; e_stb = 0; idx = -1;
      for (int i = 0; i < ev.size(); i++) begin
        if (rec && k == ev[i]) begin e_mem = 1; e_we = 1; e_start = 1; idx = i; end
        if (!rec && k == ev[i] - 1) begin e_mem = 1; idx = i; end
        if (!rec && k == ev[i] + 1) begin e_stb = 1; idx = i; end
      end
      if (rec && n != 0 && k == 1) e_start = 1;
      chk(mem_en == e_mem, rec ? "R4" : "R6", "mem_en", mem_en, e_mem);
      chk(mem_we == e_we, "R3", "mem_we", mem_we, e_we);
      chk(adc_start == e_start, rec && k == 1 ? "R2" : "R8", "adc_start", adc_start, e_start);
      chk(done == (k == done_c), "R7", "done", done, k == done_c);
      chk(active == (k <= done_c), "R9", "active", active, k <= done_c);
      chk(dac_stb == e_stb, "R6", "dac_stb", dac_stb, e_stb);
      if (e_mem && idx >= 0)
        chk(mem_addr == 8'(int'(b) + idx), "R4", "mem_addr", mem_addr, 8'(int'(b) + idx));
      if (e_we && !(fst && idx == 0))
        chk(mem_wdata == cval(n0 + idx), "R4", "captured byte", mem_wdata, cval(n0 + idx));
      if (e_stb) exp_dac = ram[8'(int'(b) + idx)];
      chk(dac_out == exp_dac, "R6", "dac_out", dac_out, exp_dac);
    end
    go = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'(i ^ 8'h5A);
    repeat (3) @(negedge clk);
    chk(!active && !done && !adc_start && !mem_en && !dac_stb && dac_out == 0,
        "R1", "outputs in reset", {active, done, adc_start, mem_en, dac_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!active && !done && !adc_start && !mem_en && !mem_we && dac_out == 0,
        "R1", "outputs after reset", {active, done, adc_start, mem_en, mem_we}, 0);
    run_pass(1'b1, 1'b0, 8'd10, 5, 8'd3, 0);   // R3 R5: busy-limited period 11
    run_pass(1'b1, 1'b0, 8'd40, 4, 8'd12, 0);  // R5: pace-limited period 14
    run_pass(1'b0, 1'b0, 8'd10, 5, 8'd1, 0);   // R6: replay recorded bytes
    run_pass(1'b0, 1'b0, 8'd40, 4, 8'd0, 0);   // R5: pace zero acts as one
    run_pass(1'b1, 1'b1, 8'd80, 4, 8'd10, 0);  // R10: fast mode
    run_pass(1'b1, 1'b0, 8'd90, 0, 8'd5, 0);   // R8: zero length record
    run_pass(1'b0, 1'b0, 8'd90, 0, 8'd5, 0);   // R8: zero length playback
    run_pass(1'b0, 1'b0, 8'd10, 3, 8'd4, 4);   // R9: go during pass ignored
    run_pass(1'b1, 1'b0, 8'd254, 4, 8'd2, 0);  // R4: address wraps
    run_pass(1'b0, 1'b0, 8'd254, 4, 8'd2, 0);  // R6: replay across wrap
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule